// File: doc/BRIEF.md
# GPIO Task-Event Channel Unit

This block gives a small set of channels, each tied through its configuration to one general-purpose pin. A channel is switched off, watches its pin for a chosen transition, or drives its pin in response to task strobes. In watch mode a matching transition on the synchronised pin raises a sticky event flag. Software clears the flag by writing zero. In drive mode the channel owns its pin's output enable and level. The level starts at the configured initial value. After that, three task registers change it: a polarity-dependent OUT task, an unconditional SET task and an unconditional CLR task.

Software reaches everything through a word-addressed register bus. Bits [7:4] of the address pick a register group and bits [3:0] pick the channel. Writes take effect on the next rising clock edge. Read data is combinational from the address. The interrupt line is the OR of every set event flag masked by its enable bit. The enable mask is changed through a write-1-to-set register and a write-1-to-clear register.

Top module: `tev_unit`

## Requirements
- R1: After reset every pin has output enable 0, the interrupt is low, and every configuration word and event flag reads back 0.
- R2: A configuration word holds mode in bits [1:0], polarity in bits [5:4], pin select in bits [11:8] and initial level in bit 16. It is written at 0x60+ch and read back unchanged. Mode encodes as 0 off, 1 watch and 3 drive. The reserved mode 2 behaves as off: the pin is not driven and no flag is raised.
- R3: In watch mode, polarity 1 flags a low-to-high pin change, 2 flags high-to-low, 3 flags either and 0 flags nothing. An input change before clock edge k is visible in the flag at 0x30+ch after edge k+2 and not after edge k+1.
- R4: A set event flag stays 1. Writing 1 to it leaves it set. Writing 0 clears it.
- R5: When an edge hit and a software clear of the same flag land on the same edge, the flag ends up set.
- R6: Each configuration write that selects drive mode loads the channel level with the initial-level bit and asserts output enable on the selected pin from the next cycle.
- R7: Writing 1 to the OUT task (0x00+ch) of a drive-mode channel sets the level for polarity 1, clears it for 2, inverts it for 3 and leaves it for 0.
- R8: Writing 1 to SET (0x10+ch) drives the level high and writing 1 to CLR (0x20+ch) drives it low, whatever the polarity.
- R9: Task strobes to a channel that is not in drive mode have no effect, and a channel in drive mode never raises its event flag.
- R10: The enable mask is set by writing ones at 0x40 and cleared by writing ones at 0x50. Either address reads back the mask. The interrupt is high exactly when some channel has both its flag and its enable bit set.
- R11: Writing 0 to a configuration word returns the channel to off and releases its pin.
- R12: When several drive-mode channels select the same pin, the lowest-numbered one sets its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address: group in [7:4], channel in [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Driven pin levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
Watch mode is exercised over every polarity paired with both a rising and a falling input change. This separates a detector that ignores polarity from one that swaps rise and fall or misses one side of the toggle case. Drive mode is exercised over every polarity from both initial levels. A single OUT strobe shows whether set, clear, invert and hold are each applied to the right code, and whether the initial level was loaded at all. Directed cases then probe the exact synchroniser latency, the collision of a hit with a clear, strobes to channels in the wrong mode, two channels contending for one pin, and the release of a pin when its configuration is zeroed.

// File: rtl/tev_pkg.sv
package tev_pkg;

    localparam int PIN_SEL_W   = 4;
    localparam int BUS_DW      = 32;
    localparam int GRP_W       = 4;

    // Register groups, selected by address bits [7:4]
    localparam logic [GRP_W-1:0] GRP_OUT     = 4'h0;
    localparam logic [GRP_W-1:0] GRP_SET     = 4'h1;
    localparam logic [GRP_W-1:0] GRP_CLR     = 4'h2;
    localparam logic [GRP_W-1:0] GRP_FLAG    = 4'h3;
    localparam logic [GRP_W-1:0] GRP_IEN_SET = 4'h4;
    localparam logic [GRP_W-1:0] GRP_IEN_CLR = 4'h5;
    localparam logic [GRP_W-1:0] GRP_CFG     = 4'h6;

    // Configuration word field positions
    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_POL_LSB  = 4;
    localparam int CFG_PIN_LSB  = 8;
    localparam int CFG_INIT_BIT = 16;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_WATCH = 2'd1,
        MODE_RSVD  = 2'd2,
        MODE_DRIVE = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_RISE = 2'd1,
        POL_FALL = 2'd2,
        POL_BOTH = 2'd3
    } pol_e;

    typedef struct packed {
        mode_e                mode;
        pol_e                 pol;
        logic [PIN_SEL_W-1:0] pin;
        logic                 init;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [BUS_DW-1:0] w);
        cfg_t c;
        c.mode = mode_e'(w[CFG_MODE_LSB +: 2]);
        c.pol  = pol_e'(w[CFG_POL_LSB +: 2]);
        c.pin  = w[CFG_PIN_LSB +: PIN_SEL_W];
        c.init = w[CFG_INIT_BIT];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] cfg_pack(input cfg_t c);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[CFG_MODE_LSB +: 2]        = c.mode;
        w[CFG_POL_LSB +: 2]         = c.pol;
        w[CFG_PIN_LSB +: PIN_SEL_W] = c.pin;
        w[CFG_INIT_BIT]             = c.init;
        return w;
    endfunction

    function automatic logic edge_match(input pol_e p, input logic rise, input logic fall);
        case (p)
            POL_RISE: return rise;
            POL_FALL: return fall;
            POL_BOTH: return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic out_task_level(input pol_e p, input logic cur);
        case (p)
            POL_RISE: return 1'b1;
            POL_FALL: return 1'b0;
            POL_BOTH: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tev_pin_sync.sv
module tev_pin_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_rise,
    output logic [NUM_PINS-1:0] pin_fall
);
    logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pin_rise = sync_q & ~prev_q;
    assign pin_fall = ~sync_q & prev_q;

    // R3: a synchronised rise traces back to the raw input two edges earlier
    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_chk
            p_sync_depth_r3: assert property (@(posedge clk) disable iff (rst)
                pin_rise[p] |-> $past(meta_q[p]))
                else $error("sync depth");
        end
    endgenerate
endmodule

// File: rtl/tev_channel.sv
module tev_channel
    import tev_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  cfg_t                cfg_wr,
    input  logic                out_stb,
    input  logic                set_stb,
    input  logic                clr_stb,
    input  logic                flag_clr,
    input  logic [NUM_PINS-1:0] pin_rise,
    input  logic [NUM_PINS-1:0] pin_fall,
    output cfg_t                cfg_q,
    output logic                flag_q,
    output logic                drive_en,
    output logic                drive_lvl
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             pin_ok;
    logic [IDX_W-1:0] pin_idx;
    logic             sel_rise, sel_fall, hit;

    assign pin_ok   = 32'(cfg_q.pin) < NUM_PINS;
    assign pin_idx  = cfg_q.pin[IDX_W-1:0];
    assign sel_rise = pin_ok && pin_rise[pin_idx];
    assign sel_fall = pin_ok && pin_fall[pin_idx];
    assign hit      = (cfg_q.mode == MODE_WATCH) && edge_match(cfg_q.pol, sel_rise, sel_fall);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wr;
    end

    // Hardware set has priority over the software clear
    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_lvl <= 1'b0;
        end else if (cfg_we && cfg_wr.mode == MODE_DRIVE) begin
            drive_lvl <= cfg_wr.init;
        end else if (cfg_q.mode == MODE_DRIVE) begin
            if (set_stb)      drive_lvl <= 1'b1;
            else if (clr_stb) drive_lvl <= 1'b0;
            else if (out_stb) drive_lvl <= out_task_level(cfg_q.pol, drive_lvl);
        end
    end

    assign drive_en = (cfg_q.mode == MODE_DRIVE) && pin_ok;

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        flag_q && !flag_clr |=> flag_q) else $error("flag dropped");

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q) else $error("hit lost");

    p_watch_only_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_q && cfg_q.mode != MODE_WATCH |=> !flag_q) else $error("flag outside watch");

    p_init_load_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wr.mode == MODE_DRIVE |=> drive_lvl == $past(cfg_wr.init))
        else $error("init level");

    p_set_task_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_we && set_stb && cfg_q.mode == MODE_DRIVE |=> drive_lvl)
        else $error("set task");

    p_clr_task_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_we && clr_stb && !set_stb && cfg_q.mode == MODE_DRIVE |=> !drive_lvl)
        else $error("clr task");

    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_wr == '0 |=> !drive_en) else $error("pin not released");
endmodule

// File: rtl/tev_pin_drive.sv
module tev_pin_drive
    import tev_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_CH-1:0]                drive_en,
    input  logic [NUM_CH-1:0]                drive_lvl,
    input  logic [NUM_CH-1:0][PIN_SEL_W-1:0] drive_pin,
    output logic [NUM_PINS-1:0]              pin_out,
    output logic [NUM_PINS-1:0]              pin_oe
);
    // Walk channels from highest to lowest so the lowest index is written last
    always_comb begin
        pin_out = '0;
        pin_oe  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (drive_en[c] && drive_pin[c] == PIN_SEL_W'(p)) begin
                    pin_out[p] = drive_lvl[c];
                    pin_oe[p]  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tev_unit.sv
module tev_unit
    import tev_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int IDX_W = 4;
    localparam int PIDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    assign grp = bus_addr[7:4];
    assign idx = bus_addr[3:0];

    logic [NUM_PINS-1:0] pin_rise, pin_fall;
    logic [NUM_CH-1:0]   flags, drv_en, drv_lvl, ien_q;
    logic [NUM_CH-1:0][PIN_SEL_W-1:0] drv_pin;
    cfg_t                cfg_arr [NUM_CH];
    cfg_t                cfg_wr;

    assign cfg_wr = cfg_unpack(bus_wdata);

    tev_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .pin_rise(pin_rise), .pin_fall(pin_fall)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic sel;
            assign sel = bus_we && (idx == IDX_W'(c));
            tev_channel #(.NUM_PINS(NUM_PINS)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .cfg_we   (sel && grp == GRP_CFG),
                .cfg_wr   (cfg_wr),
                .out_stb  (sel && grp == GRP_OUT && bus_wdata[0]),
                .set_stb  (sel && grp == GRP_SET && bus_wdata[0]),
                .clr_stb  (sel && grp == GRP_CLR && bus_wdata[0]),
                .flag_clr (sel && grp == GRP_FLAG && !bus_wdata[0]),
                .pin_rise (pin_rise),
                .pin_fall (pin_fall),
                .cfg_q    (cfg_arr[c]),
                .flag_q   (flags[c]),
                .drive_en (drv_en[c]),
                .drive_lvl(drv_lvl[c])
            );
            assign drv_pin[c] = cfg_arr[c].pin;
        end
    endgenerate

    tev_pin_drive #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS)) u_drive (
        .drive_en(drv_en), .drive_lvl(drv_lvl), .drive_pin(drv_pin),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (bus_we && idx == '0) begin
            if (grp == GRP_IEN_SET)      ien_q <= ien_q | bus_wdata[NUM_CH-1:0];
            else if (grp == GRP_IEN_CLR) ien_q <= ien_q & ~bus_wdata[NUM_CH-1:0];
        end
    end

    assign irq = |(flags & ien_q);

    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_IEN_SET, GRP_IEN_CLR: bus_rdata[NUM_CH-1:0] = ien_q;
            GRP_FLAG: begin
                for (int k = 0; k < NUM_CH; k++)
                    if (idx == IDX_W'(k)) bus_rdata[0] = flags[k];
            end
            GRP_CFG: begin
                for (int k = 0; k < NUM_CH; k++)
                    if (idx == IDX_W'(k)) bus_rdata = cfg_pack(cfg_arr[k]);
            end
            default: bus_rdata = '0;
        endcase
    end

    p_ien_clear_r10: assert property (@(posedge clk) disable iff (rst)
        bus_we && grp == GRP_IEN_CLR && idx == '0 && (&bus_wdata[NUM_CH-1:0]) |=> !irq)
        else $error("irq after full disable");

    p_ien_set_r10: assert property (@(posedge clk) disable iff (rst)
        bus_we && grp == GRP_IEN_SET && idx == '0 && bus_wdata[0] && flags[0] && !(grp == GRP_FLAG)
        |=> irq || !flags[0]) else $error("irq missing");

    p_owner_r12: assert property (@(posedge clk) disable iff (rst)
        drv_en[0] && drv_en[1] && drv_pin[0] == drv_pin[1]
        |-> pin_out[drv_pin[0][PIDX_W-1:0]] == drv_lvl[0]) else $error("pin owner");
endmodule

// File: tb/tev_unit_tb.sv
`timescale 1ns/1ps
module tev_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    tev_unit u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // [7] 0 watch / 1 drive, [5:4] polarity, [1] start level or initial level, [0] expected
    localparam logic [7:0] VEC [16] = '{
        8'h00, 8'h02, 8'h11, 8'h12, 8'h20, 8'h23, 8'h31, 8'h33,
        8'h80, 8'h83, 8'h91, 8'h93, 8'hA0, 8'hA2, 8'hB1, 8'hB2
    };

    function automatic logic [31:0] cfgw(input logic [1:0] m, input logic [3:0] pin,
                                         input logic [1:0] pol, input logic init);
        return {15'b0, init, 4'b0, pin, 2'b0, pol, 2'b0, m};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        chk("R1 oe", {24'b0, pin_oe}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(8'h60, rv); chk("R1 cfg", rv, 32'h0);
        rd(8'h30, rv); chk("R1 flag", rv, 32'h0);

        // Vector walk: R3 watch polarities, R6/R7 drive polarities
        for (int i = 0; i < 16; i++) begin
            logic [1:0] pol;
            logic       st, ex;
            pol = VEC[i][5:4]; st = VEC[i][1]; ex = VEC[i][0];
            if (!VEC[i][7]) begin
                wr(8'h60, cfgw(2'd1, 4'd0, pol, 1'b0));
                pin_in[0] = st;
                idle(4);
                wr(8'h30, 32'h0);
                pin_in[0] = ~st;
                idle(4);
                rd(8'h30, rv);
                chk($sformatf("R3 vec%0d", i), rv, {31'b0, ex});
            end else begin
                wr(8'h60, cfgw(2'd3, 4'd1, pol, st));
                chk($sformatf("R6 vec%0d", i), {30'b0, pin_oe[1], pin_out[1]}, {30'b0, 1'b1, st});
                wr(8'h00, 32'h1);
                chk($sformatf("R7 vec%0d", i), {31'b0, pin_out[1]}, {31'b0, ex});
            end
        end

        // R3 exact latency: change before edge k, flag after k+2 only
        wr(8'h60, cfgw(2'd1, 4'd0, 2'd1, 1'b0));
        pin_in[0] = 1'b0; idle(4); wr(8'h30, 32'h0);
        bus_addr = 8'h30;
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 not after k+1", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R3 set after k+2", bus_rdata, 32'h1);

        // R4 sticky flag
        wr(8'h30, 32'h1); rd(8'h30, rv); chk("R4 write1 keeps", rv, 32'h1);

        // R10 interrupt enables
        chk("R10 masked", {31'b0, irq}, 32'h0);
        wr(8'h40, 32'h1);
        chk("R10 irq on", {31'b0, irq}, 32'h1);
        rd(8'h40, rv); chk("R10 read set", rv, 32'h1);
        rd(8'h50, rv); chk("R10 read clr", rv, 32'h1);
        wr(8'h50, 32'h1);
        chk("R10 irq off", {31'b0, irq}, 32'h0);
        rd(8'h40, rv); chk("R10 mask cleared", rv, 32'h0);

        wr(8'h30, 32'h0); rd(8'h30, rv); chk("R4 write0 clears", rv, 32'h0);

        // R5 hit and clear on the same edge
        pin_in[0] = 1'b0; idle(4); wr(8'h30, 32'h0);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0;
        @(negedge clk); bus_we = 1'b0;
        #1 chk("R5 set wins", bus_rdata, 32'h1);

        // R8 set/clear regardless of polarity
        wr(8'h60, cfgw(2'd3, 4'd1, 2'd1, 1'b0));
        wr(8'h10, 32'h1); chk("R8 set pol1", {31'b0, pin_out[1]}, 32'h1);
        wr(8'h20, 32'h1); chk("R8 clr pol1", {31'b0, pin_out[1]}, 32'h0);
        wr(8'h60, cfgw(2'd3, 4'd1, 2'd2, 1'b0));
        wr(8'h10, 32'h1); chk("R8 set pol2", {31'b0, pin_out[1]}, 32'h1);
        wr(8'h60, cfgw(2'd3, 4'd1, 2'd1, 1'b1));
        wr(8'h20, 32'h1); chk("R8 clr pol1 high", {31'b0, pin_out[1]}, 32'h0);

        // R9 strobes ignored outside drive mode; no flags in drive mode
        wr(8'h13, 32'h1); chk("R9 off no drive", {31'b0, pin_oe[5]}, 32'h0);
        wr(8'h63, cfgw(2'd1, 4'd5, 2'd1, 1'b0));
        wr(8'h13, 32'h1); chk("R9 watch no drive", {31'b0, pin_oe[5]}, 32'h0);
        wr(8'h03, 32'h1);
        wr(8'h63, cfgw(2'd3, 4'd5, 2'd0, 1'b0));
        chk("R9 level untouched", {30'b0, pin_oe[5], pin_out[5]}, 32'h2);
        pin_in[5] = 1'b1; idle(4);
        rd(8'h33, rv); chk("R9 no flag in drive", rv, 32'h0);

        // R2 readback and reserved mode
        wr(8'h62, cfgw(2'd1, 4'd6, 2'd2, 1'b1));
        rd(8'h62, rv); chk("R2 readback", rv, 32'h0001_0621);
        wr(8'h62, cfgw(2'd2, 4'd6, 2'd3, 1'b1));
        chk("R2 reserved no drive", {31'b0, pin_oe[6]}, 32'h0);
        pin_in[6] = 1'b1; idle(4);
        rd(8'h32, rv); chk("R2 reserved no flag", rv, 32'h0);

        // R12 shared pin, R11 release
        wr(8'h61, cfgw(2'd3, 4'd3, 2'd0, 1'b0));
        wr(8'h62, cfgw(2'd3, 4'd3, 2'd0, 1'b1));
        chk("R12 lowest wins", {30'b0, pin_oe[3], pin_out[3]}, 32'h2);
        wr(8'h61, 32'h0);
        chk("R11 next owner", {30'b0, pin_oe[3], pin_out[3]}, 32'h3);
        wr(8'h62, 32'h0);
        chk("R11 released", {31'b0, pin_oe[3]}, 32'h0);
        rd(8'h62, rv); chk("R11 cfg zero", rv, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule